// File: doc/BRIEF.md
# Error-Tolerant Instruction Field Decoder

This block takes one 64-bit instruction word from an evolved program and turns it into an opcode, three register indices (source s, source t, destination d), a NOP flag and one "repaired" flag per register field. The register fields are Gray-coded numbers guarded by three parity bits. A single flipped bit in any register field is repaired before the Gray number is turned into binary. An opcode field that is damaged or out of range becomes a NOP. A randomly mutated word therefore always yields something safe to run. Execution, immediates and control flow are handled elsewhere.

Words enter through a valid/ready handshake. Each result appears one cycle later in an output register that honours full backpressure. The output register is a two-state machine. `ST_EMPTY` means no result is held; it moves to `ST_FULL` when a word is accepted. `ST_FULL` means a result is held. It stays in `ST_FULL` when the consumer stalls, or when the result is taken and a new word arrives in the same cycle. It returns to `ST_EMPTY` when the result is taken and no new word arrives. The parameter `REG_BITS` chooses 16-register mode (4) or 32-register mode (5).

Top module: `evo_insn_decoder`

## Requirements
- R1: In 16-register mode, bits [6:4] of a register slot are the parity bits p0,p1,p2 and bits [3:0] are the Gray digits a,b,c,d, with a at bit 3. p0=a^b^c, p1=b^c^d and p2=c^d^a. A slot whose parity matches decodes to the binary value of the Gray number abcd, and its repaired flag is 0. Examples: 8'h00=0, 8'h31=1, 8'h43=2, 8'h72=3, 8'h16=4, 8'h27=5, 8'h7F=10, 8'h58=15.
- R2: The syndrome is {p0,p1,p2} received XOR recomputed. In 16-register mode, syndromes 101, 110, 111 and 011 flip a, b, c and d respectively before the Gray-to-binary step, and the repaired flag for that field is set.
- R3: In 16-register mode, a syndrome with a single bit set (100, 010, 001) leaves the register number unchanged and sets the repaired flag.
- R4: In 16-register mode, bit 7 of each register slot has no effect on any output.
- R5: Slot rs is word[47:40], rt is word[39:32] and rd is word[31:24]. out_fixed bit 2 belongs to rs, bit 1 to rt and bit 0 to rd. Word bits [23:0] have no effect on any output.
- R6: The opcode field is word[63:48]. Its upper OPC_BITS bits hold the opcode value and its lower 16-OPC_BITS bits hold the bitwise complement of the low bits of that value. With 8 bits: 16'h05FA gives opcode 5 and out_nop=0.
- R7: If the complement part does not match, out_nop is 1 and out_opcode is 0.
- R8: If the opcode value is OP_COUNT (default 200) or larger, out_nop is 1 and out_opcode is 0. A value of OP_COUNT-1 is legal.
- R9: A word accepted at a clock edge (in_valid and in_ready both 1) is presented with out_valid=1 immediately after that edge.
- R10: While out_valid=1 and out_ready=0, in_ready is 0 and all outputs hold their values. Once out_ready=1, a waiting word is accepted and shown on the next edge. If no word is waiting, out_valid falls.
- R11: During and right after reset, out_valid is 0 and in_ready is 1.
- R12: In 32-register mode, a slot is {p0,p1,p2,e,a,b,c,d} from bit 7 down to bit 0, with p0=a^b^c, p1=b^c^d and p2=c^d^e. The Gray number is {a,b,c,d,e} with a as MSB. Syndromes 110, 111 and 011 flip b, c and d.
- R13: In 32-register mode, syndromes 100, 010, 001 and 101 leave the Gray digits unchanged, and any nonzero syndrome sets the repaired flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is offered |
| in_ready | output | 1 | Decoder can take a word this cycle |
| in_word | input | 64 | Raw instruction word |
| out_valid | output | 1 | Decoded result is held |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_opcode | output | OPC_BITS | Opcode value, 0 when NOP |
| out_rs | output | REG_BITS | First source register index |
| out_rt | output | REG_BITS | Second source register index |
| out_rd | output | REG_BITS | Destination register index |
| out_nop | output | 1 | Opcode field was unusable, treat as NOP |
| out_fixed | output | 3 | Nonzero syndrome in {rs, rt, rd} |

## Verification
The register fields are tried in four patterns:
- clean codewords, including every example encoding listed in R1;
- a single flipped data bit at each of the four Gray positions;
- a single flipped parity bit;
- slots with the spare top bit set.

Together these separate the data-repair path from the parity-only path and expose a wrong syndrome-to-bit mapping. The opcode field is tried with:
- matching values at 0, 5 and the last legal value;
- the first value past the limit;
- 8'hFF;
- a broken complement.

These pin down the range compare and the integrity check separately. A second instance in 32-register mode receives flips that it can repair and flips that are ambiguous. Stall and release sequences show that nothing is lost or changed under backpressure.

// File: rtl/evo_dec_pkg.sv
package evo_dec_pkg;

    localparam int SLOT_W   = 8;
    localparam int OPF_W    = 16;
    localparam int OPF_HI   = 63;
    localparam int SLOT0_HI = 47;
    localparam int N_FIELDS = 3;

    typedef enum logic [0:0] {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_t;

endpackage

// File: rtl/evo_reg_field_fix.sv
module evo_reg_field_fix #(
    parameter int REG_BITS = 4
) (
    input  logic [7:0]          slot,
    output logic [REG_BITS-1:0] reg_idx,
    output logic                fixed
);

    logic [REG_BITS-1:0] gray_fixed;

    generate
        if (REG_BITS == 4) begin : g_mode16
            logic       unused_spare;
            logic [2:0] par_rx;
            logic [2:0] par_calc;
            logic [2:0] syn;
            logic [3:0] flip;
            logic       da, db, dc, dd;

            assign unused_spare = slot[7];
            assign par_rx = slot[6:4];
            assign da = slot[3];
            assign db = slot[2];
            assign dc = slot[1];
            assign dd = slot[0];

            always_comb begin
                par_calc = {da ^ db ^ dc, db ^ dc ^ dd, dc ^ dd ^ da};
                syn      = par_rx ^ par_calc;
                unique case (syn)
                    3'b101:  flip = 4'b1000;
                    3'b110:  flip = 4'b0100;
                    3'b111:  flip = 4'b0010;
                    3'b011:  flip = 4'b0001;
                    default: flip = 4'b0000;
                endcase
                gray_fixed = slot[3:0] ^ flip;
                fixed      = |syn;
            end

            // after repair the word sits within one bit of a codeword
            always_comb begin
                AST_CODEWORD_CLOSE: assert ($countones(par_rx ^ {gray_fixed[3] ^ gray_fixed[2] ^ gray_fixed[1],
                                                                   gray_fixed[2] ^ gray_fixed[1] ^ gray_fixed[0],
                                                                   gray_fixed[1] ^ gray_fixed[0] ^ gray_fixed[3]}) <= 1); // R2
            end
        end else begin : g_mode32
            logic [2:0] par_rx;
            logic [2:0] par_calc;
            logic [2:0] syn;
            logic [4:0] flip;
            logic       da, db, dc, dd, de;

            assign par_rx = slot[7:5];
            assign de = slot[4];
            assign da = slot[3];
            assign db = slot[2];
            assign dc = slot[1];
            assign dd = slot[0];

            always_comb begin
                par_calc = {da ^ db ^ dc, db ^ dc ^ dd, dc ^ dd ^ de};
                syn      = par_rx ^ par_calc;
                unique case (syn)
                    3'b110:  flip = 5'b01000;
                    3'b111:  flip = 5'b00100;
                    3'b011:  flip = 5'b00010;
                    default: flip = 5'b00000;
                endcase
                gray_fixed = {da, db, dc, dd, de} ^ flip;
                fixed      = |syn;
            end
        end
    endgenerate

    always_comb begin
        reg_idx[REG_BITS-1] = gray_fixed[REG_BITS-1];
        for (int i = REG_BITS - 2; i >= 0; i--) begin
            reg_idx[i] = reg_idx[i+1] ^ gray_fixed[i];
        end
    end

endmodule

// File: rtl/evo_opcode_check.sv
module evo_opcode_check #(
    parameter int OPC_BITS = 8,
    parameter int OP_COUNT = 200
) (
    input  logic [15:0]         field,
    output logic [OPC_BITS-1:0] opcode,
    output logic                nop
);

    localparam int CHK_W = 16 - OPC_BITS;
    localparam logic [OPC_BITS:0] LIMIT = OP_COUNT[OPC_BITS:0];

    logic [OPC_BITS-1:0] value;
    logic [CHK_W-1:0]    check;
    logic                mismatch;
    logic                out_of_range;

    assign value = field[15 -: OPC_BITS];
    assign check = field[CHK_W-1:0];

    always_comb begin
        mismatch     = (check != ~value[CHK_W-1:0]);
        out_of_range = ({1'b0, value} >= LIMIT);
        nop          = mismatch || out_of_range;
        opcode       = nop ? '0 : value;
    end

endmodule

// File: rtl/evo_out_stage.sv
module evo_out_stage
    import evo_dec_pkg::*;
#(
    parameter int PAY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PAY_W-1:0] in_payload,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PAY_W-1:0] out_payload
);

    stage_state_t state, state_nx;
    logic [PAY_W-1:0] hold_q;
    logic             take;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (in_valid) state_nx = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) state_nx = ST_EMPTY;
            default:  state_nx = ST_EMPTY;
        endcase
    end

    always_comb begin
        in_ready    = (state == ST_EMPTY) || out_ready;
        out_valid   = (state == ST_FULL);
        out_payload = hold_q;
        take        = in_valid && in_ready;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    hold_q <= '0;
        else if (take) hold_q <= in_payload;
    end

    AST_ACCEPT_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid); // R9
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_payload))); // R10

endmodule

// File: rtl/evo_insn_decoder.sv
module evo_insn_decoder
    import evo_dec_pkg::*;
#(
    parameter int REG_BITS = 4,
    parameter int OPC_BITS = 8,
    parameter int OP_COUNT = 200
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [63:0]         in_word,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [OPC_BITS-1:0] out_opcode,
    output logic [REG_BITS-1:0] out_rs,
    output logic [REG_BITS-1:0] out_rt,
    output logic [REG_BITS-1:0] out_rd,
    output logic                out_nop,
    output logic [2:0]          out_fixed
);

    localparam int PAY_W = 1 + OPC_BITS + N_FIELDS * REG_BITS + N_FIELDS;
    localparam logic [OPC_BITS:0] LIMIT = OP_COUNT[OPC_BITS:0];

    logic [REG_BITS-1:0] dec_idx [N_FIELDS];
    logic [N_FIELDS-1:0] dec_fix;
    logic [OPC_BITS-1:0] dec_op;
    logic                dec_nop;
    logic [23:0]         unused_low;
    logic [PAY_W-1:0]    pay_in;
    logic [PAY_W-1:0]    pay_out;

    assign unused_low = in_word[23:0];

    genvar gi;
    generate
        for (gi = 0; gi < N_FIELDS; gi++) begin : g_field
            evo_reg_field_fix #(
                .REG_BITS (REG_BITS)
            ) i_fix (
                .slot    (in_word[SLOT0_HI - gi*SLOT_W -: SLOT_W]),
                .reg_idx (dec_idx[gi]),
                .fixed   (dec_fix[N_FIELDS-1-gi])
            );
        end
    endgenerate

    evo_opcode_check #(
        .OPC_BITS (OPC_BITS),
        .OP_COUNT (OP_COUNT)
    ) i_opc (
        .field  (in_word[OPF_HI -: OPF_W]),
        .opcode (dec_op),
        .nop    (dec_nop)
    );

    assign pay_in = {dec_nop, dec_op, dec_idx[0], dec_idx[1], dec_idx[2], dec_fix};

    evo_out_stage #(
        .PAY_W (PAY_W)
    ) i_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_payload  (pay_in),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_payload (pay_out)
    );

    assign {out_nop, out_opcode, out_rs, out_rt, out_rd, out_fixed} = pay_out;

    AST_LEGAL_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_nop) |-> ({1'b0, out_opcode} < LIMIT)); // R8
    AST_NOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nop) |-> (out_opcode == '0)); // R7

endmodule

// File: tb/test_evo_insn_decoder.sv
module test_evo_insn_decoder;

    typedef struct packed {
        logic [15:0] opf;
        logic [7:0]  rs;
        logic [7:0]  rt;
        logic [7:0]  rd;
        logic [23:0] low;
        logic        nop;
        logic [7:0]  op;
        logic [3:0]  ers;
        logic [3:0]  ert;
        logic [3:0]  erd;
        logic [2:0]  fix;
    } vec_t;

    // R1 R2 R3 R4 R5 R6 R7 R8 walked by the table
    localparam vec_t VECS [6] = '{
        '{16'h05FA, 8'h31, 8'h43, 8'h72, 24'h000000, 1'b0, 8'h05, 4'd1, 4'd2,  4'd3,  3'b000},
        '{16'h00FF, 8'h16, 8'h27, 8'h58, 24'hFFFFFF, 1'b0, 8'h00, 4'd4, 4'd5,  4'd15, 3'b000},
        '{16'hC738, 8'h30, 8'h4B, 8'h76, 24'hA5A5A5, 1'b0, 8'hC7, 4'd1, 4'd2,  4'd3,  3'b111},
        '{16'hC837, 8'h56, 8'h7D, 8'h10, 24'h5A5A5A, 1'b1, 8'h00, 4'd4, 4'd10, 4'd0,  3'b111},
        '{16'h05F0, 8'hB1, 8'h80, 8'hFF, 24'h123456, 1'b1, 8'h00, 4'd1, 4'd0,  4'd10, 3'b000},
        '{16'hFF00, 8'h41, 8'h00, 8'h27, 24'hFFFFFF, 1'b1, 8'h00, 4'd2, 4'd0,  4'd5,  3'b100}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        out_ready = 1'b1;
    logic [63:0] in_word = '0;

    logic       in_ready, out_valid, out_nop;
    logic [7:0] out_opcode;
    logic [3:0] out_rs, out_rt, out_rd;
    logic [2:0] out_fixed;

    logic       w_in_ready, w_out_valid, w_out_nop;
    logic [7:0] w_out_opcode;
    logic [4:0] w_out_rs, w_out_rt, w_out_rd;
    logic [2:0] w_out_fixed;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    evo_insn_decoder i_evo_insn_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_opcode(out_opcode), .out_rs(out_rs), .out_rt(out_rt), .out_rd(out_rd),
        .out_nop(out_nop), .out_fixed(out_fixed)
    );

    evo_insn_decoder #(.REG_BITS(5)) i_evo_insn_decoder_wide (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(w_in_ready),
        .in_word(in_word), .out_valid(w_out_valid), .out_ready(out_ready),
        .out_opcode(w_out_opcode), .out_rs(w_out_rs), .out_rt(w_out_rt), .out_rd(w_out_rd),
        .out_nop(w_out_nop), .out_fixed(w_out_fixed)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] enc5(input int n);
        logic [4:0] g;
        g = 5'(n) ^ (5'(n) >> 1);
        return {g[4] ^ g[3] ^ g[2], g[3] ^ g[2] ^ g[1], g[2] ^ g[1] ^ g[0], g[0], g[4], g[3], g[2], g[1]};
    endfunction

    function automatic logic [4:0] g2b5(input logic [4:0] g);
        logic [4:0] b;
        b[4] = g[4];
        for (int i = 3; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    // drive at negedge, accepted on next posedge, sample at the negedge after
    task automatic send(input logic [63:0] w);
        @(negedge clk);
        in_word  = w;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] w;
        logic [4:0]  g13;
        repeat (3) @(negedge clk);
        check("R11 out_valid in reset", 32'(out_valid), 0);
        check("R11 in_ready in reset", 32'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 out_valid after reset", 32'(out_valid), 0);
        check("R11 in_ready after reset", 32'(in_ready), 1);

        for (int k = 0; k < 6; k++) begin
            send({VECS[k].opf, VECS[k].rs, VECS[k].rt, VECS[k].rd, VECS[k].low});
            check("R9 out_valid one cycle after accept", 32'(out_valid), 1);
            check("R6 R7 R8 nop flag", 32'(out_nop), 32'(VECS[k].nop));
            check("R6 R7 R8 opcode", 32'(out_opcode), 32'(VECS[k].op));
            check("R1 R2 R3 R4 R5 rs", 32'(out_rs), 32'(VECS[k].ers));
            check("R1 R2 R3 R4 R5 rt", 32'(out_rt), 32'(VECS[k].ert));
            check("R1 R2 R3 R4 R5 rd", 32'(out_rd), 32'(VECS[k].erd));
            check("R2 R3 R5 repaired flags", 32'(out_fixed), 32'(VECS[k].fix));
        end

        // R10: stall holds the result and blocks input
        @(negedge clk);
        out_ready = 1'b0;
        send({16'h05FA, 8'h31, 8'h43, 8'h72, 24'h0});
        in_word  = {16'h00FF, 8'h16, 8'h27, 8'h58, 24'h0};
        in_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 in_ready low while stalled", 32'(in_ready), 0);
        check("R10 out_valid held", 32'(out_valid), 1);
        check("R10 opcode held", 32'(out_opcode), 5);
        check("R10 rs held", 32'(out_rs), 1);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 waiting word shown after release", 32'(out_rs), 4);
        check("R10 waiting opcode after release", 32'(out_opcode), 0);
        check("R10 still valid after release", 32'(out_valid), 1);
        @(negedge clk);
        check("R10 out_valid falls when drained", 32'(out_valid), 0);

        // R12 R13 in 32-register mode
        g13 = 5'd13 ^ 5'd6;
        w = {16'h05FA, enc5(21), enc5(6) ^ 8'h04, enc5(13) ^ 8'h08, 24'h0};
        send(w);
        check("R12 wide clean rs", 32'(w_out_rs), 21);
        check("R12 wide b flip repaired", 32'(w_out_rt), 6);
        check("R13 wide a flip left as is", 32'(w_out_rd), 32'(g2b5(g13 ^ 5'b10000)));
        check("R12 R13 wide flags", 32'(w_out_fixed), 3'b011);
        w = {16'h05FA, enc5(9) ^ 8'h40, enc5(30) ^ 8'h02, enc5(17) ^ 8'h01, 24'h0};
        send(w);
        check("R13 wide parity flip keeps rs", 32'(w_out_rs), 9);
        check("R12 wide c flip repaired", 32'(w_out_rt), 30);
        check("R12 wide d flip repaired", 32'(w_out_rd), 17);
        check("R12 R13 wide flags all", 32'(w_out_fixed), 3'b111);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule